// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block drives one low-speed USB packet onto the D+/D- pair. A one-cycle start strobe launches a packet. The block first presets the pair to the idle J state and only then turns its drivers on. It then shifts out a sync byte followed by either bytes fetched from a small external buffer or a single handshake PID. All bits go least significant bit first, NRZI-coded, with a zero stuffed after every run of six ones. The packet ends with a two-bit SE0, one bit time of J, and a release of the bus with both lines low.

A handshake shortcut sends exactly two bytes: the sync byte and the PID given on a dedicated input. The declared byte count is ignored in that case. When a data packet finishes, a pending device address is moved into the active address register at the start of the end-of-packet. A handshake never commits one. As the bus is released, the block pulses a clear for any receive-start event that its own transmission raised. Every bit lasts a parameterised number of system clocks, 11 by default.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset, oe, dp, dm and busy are 0, and dev_addr is 0.
- R2: In the cycle after an accepted start, the pair shows J (dp=0, dm=1) with oe still 0. oe rises one cycle later while the pair still shows J.
- R3: The first byte on the wire is the sync byte 0x80, least significant bit first. Line coding: a data 0 flips the pair between J and K (K is dp=1, dm=0), and a data 1 holds it. The first bit appears one cycle after oe rises.
- R4: For a data packet, byte_cnt (2 to 12, sync included) sets the length. Bytes 1 to byte_cnt-1 come from buffer addresses 0 to byte_cnt-2 in order. The buffer is read combinationally through rd_addr/rd_data. Each bit lasts BIT_CLKS clocks.
- R5: After six consecutive data 1s a 0 is inserted. This applies inside a byte, across a byte boundary, and after the final byte before the end-of-packet.
- R6: With hs_sel set at start, exactly the sync byte and hs_pid are sent, whatever byte_cnt holds.
- R7: After the last bit the pair shows SE0 (both low) for two bit times and then J for one bit time with oe high. Then oe drops with both lines low. The pair never shows dp=dm=1.
- R8: busy is high from the cycle after an accepted start until the cycle the bus is released. rx_evt_clr pulses for exactly that release cycle.
- R9: If new_addr_valid is high when the end-of-packet begins, new_addr is copied to dev_addr, but only for a data packet. After a handshake, dev_addr is unchanged.
- R10: A start strobe while busy is high has no effect on the packet in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a packet |
| hs_sel | input | 1 | 1 selects the two-byte handshake shortcut |
| hs_pid | input | 8 | Handshake PID byte (ACK or NAK) |
| byte_cnt | input | 4 | Data packet length including sync, 2 to 12 |
| rd_addr | output | 4 | Buffer read address |
| rd_data | input | 8 | Buffer data at rd_addr, same cycle |
| new_addr_valid | input | 1 | A newly assigned address is pending |
| new_addr | input | 7 | Pending device address |
| dp | output | 1 | D+ drive level |
| dm | output | 1 | D- drive level |
| oe | output | 1 | Output enable for the pair drivers |
| busy | output | 1 | Packet in progress |
| dev_addr | output | 7 | Committed device address |
| rx_evt_clr | output | 1 | One-cycle clear of self-caused receive-start event |

## Verification
The assertions assume that byte_cnt lies between 2 and 12 whenever a start is accepted. They also assume that the buffer answers rd_addr combinationally, and that hs_pid and the buffer contents stay put while a packet is on the wire. The bench draws random lengths only from that legal range. It rewrites the buffer only between packets, and it changes no input during a packet except one deliberate start pulse. Directed packets ending in six ones, long all-ones payloads and both handshake PIDs cover the stuffing and shortcut corners.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACQ,
        ST_SEND,
        ST_EOP,
        ST_JEND
    } tx_state_e;

    typedef struct packed {
        logic dp;
        logic dm;
    } pair_t;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam int         STUFF_RUN = 6;

    localparam pair_t PAIR_OFF = '{dp: 1'b0, dm: 1'b0};

    function automatic pair_t line_pair(input logic is_j);
        pair_t p;
        p.dp = ~is_j;
        p.dm = is_j;
        return p;
    endfunction

endpackage

// File: rtl/usb_ls_bit_timer.sv
module usb_ls_bit_timer #(
    parameter int BIT_CLKS = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int TW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(BIT_CLKS - 1);

    logic [TW-1:0] phase_q;

    assign tick = run && (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    p_phase_bound_r4: assert property (@(posedge clk) disable iff (rst)
        phase_q <= LAST);

endmodule

// File: rtl/usb_ls_bit_serializer.sv
module usb_ls_bit_serializer
    import usb_ls_tx_pkg::*;
#(
    parameter int MAX_BYTES = 12,
    localparam int CNT_W = $clog2(MAX_BYTES + 1),
    localparam int IDX_W = $clog2(MAX_BYTES - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             hs_in,
    input  logic [7:0]       pid_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             adv,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_addr,
    output logic             bit_out,
    output logic             is_end,
    output logic             hs_q
);
    logic [7:0]       sh_q;
    logic [2:0]       bit_i_q;
    logic [CNT_W-1:0] byte_i_q;
    logic [CNT_W-1:0] total_q;
    logic [7:0]       pid_q;
    logic [2:0]       ones_q;
    logic             done_q;
    logic             stuff_now;
    logic [7:0]       next_byte;

    assign stuff_now = (ones_q == 3'(STUFF_RUN));
    assign bit_out   = stuff_now ? 1'b0 : sh_q[0];
    assign is_end    = done_q && !stuff_now;
    assign rd_addr   = IDX_W'(byte_i_q);
    assign next_byte = hs_q ? pid_q : rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            bit_i_q  <= '0;
            byte_i_q <= '0;
            total_q  <= '0;
            pid_q    <= '0;
            hs_q     <= 1'b0;
            ones_q   <= '0;
            done_q   <= 1'b0;
        end else if (load) begin
            sh_q     <= SYNC_BYTE;
            bit_i_q  <= '0;
            byte_i_q <= '0;
            total_q  <= hs_in ? CNT_W'(2) : cnt_in;
            pid_q    <= pid_in;
            hs_q     <= hs_in;
            ones_q   <= '0;
            done_q   <= 1'b0;
        end else if (adv && !is_end) begin
            if (stuff_now) begin
                ones_q <= '0;
            end else begin
                ones_q <= sh_q[0] ? ones_q + 1'b1 : 3'd0;
                if (bit_i_q == 3'd7) begin
                    bit_i_q <= '0;
                    if (CNT_W'(byte_i_q + 1'b1) == total_q) begin
                        done_q <= 1'b1;
                    end else begin
                        byte_i_q <= byte_i_q + 1'b1;
                        sh_q     <= next_byte;
                    end
                end else begin
                    bit_i_q <= bit_i_q + 1'b1;
                    sh_q    <= {1'b0, sh_q[7:1]};
                end
            end
        end
    end

    p_run_bound_r5: assert property (@(posedge clk) disable iff (rst)
        ones_q <= 3'(STUFF_RUN));

    p_stuff_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (adv && stuff_now && !load) |=> (ones_q == 3'd0));

endmodule

// File: rtl/usb_ls_addr_latch.sv
module usb_ls_addr_latch #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eop_start,
    input  logic              is_hs,
    input  logic              pend_valid,
    input  logic [ADDR_W-1:0] pend_addr,
    output logic [ADDR_W-1:0] dev_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dev_addr <= '0;
        end else if (eop_start && !is_hs && pend_valid) begin
            dev_addr <= pend_addr;
        end
    end

    p_addr_only_at_eop_r9: assert property (@(posedge clk) disable iff (rst)
        !eop_start |=> $stable(dev_addr));

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
    import usb_ls_tx_pkg::*;
#(
    parameter int BIT_CLKS  = 11,
    parameter int MAX_BYTES = 12,
    parameter int ADDR_W    = 7,
    localparam int CNT_W = $clog2(MAX_BYTES + 1),
    localparam int IDX_W = $clog2(MAX_BYTES - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              hs_sel,
    input  logic [7:0]        hs_pid,
    input  logic [CNT_W-1:0]  byte_cnt,
    output logic [IDX_W-1:0]  rd_addr,
    input  logic [7:0]        rd_data,
    input  logic              new_addr_valid,
    input  logic [ADDR_W-1:0] new_addr,
    output logic              dp,
    output logic              dm,
    output logic              oe,
    output logic              busy,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              rx_evt_clr
);
    tx_state_e state_q;
    pair_t     drv_q;
    logic      line_j_q;
    logic      half_q;
    logic      tick;
    logic      run;
    logic      load;
    logic      adv;
    logic      bit_out;
    logic      is_end;
    logic      hs_q;
    logic      eop_start;

    assign run       = (state_q == ST_SEND) || (state_q == ST_EOP) || (state_q == ST_JEND);
    assign load      = (state_q == ST_IDLE) && start;
    assign adv       = (state_q == ST_ACQ) || ((state_q == ST_SEND) && tick);
    assign eop_start = (state_q == ST_SEND) && tick && is_end;

    usb_ls_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    usb_ls_bit_serializer #(.MAX_BYTES(MAX_BYTES)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .hs_in   (hs_sel),
        .pid_in  (hs_pid),
        .cnt_in  (byte_cnt),
        .adv     (adv),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .bit_out (bit_out),
        .is_end  (is_end),
        .hs_q    (hs_q)
    );

    usb_ls_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .eop_start  (eop_start),
        .is_hs      (hs_q),
        .pend_valid (new_addr_valid),
        .pend_addr  (new_addr),
        .dev_addr   (dev_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            drv_q      <= PAIR_OFF;
            line_j_q   <= 1'b1;
            half_q     <= 1'b0;
            oe         <= 1'b0;
            busy       <= 1'b0;
            rx_evt_clr <= 1'b0;
        end else begin
            rx_evt_clr <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q  <= ST_PRE;
                        busy     <= 1'b1;
                        line_j_q <= 1'b1;
                        drv_q    <= line_pair(1'b1);
                    end
                end
                ST_PRE: begin
                    state_q <= ST_ACQ;
                    oe      <= 1'b1;
                end
                ST_ACQ: begin
                    state_q  <= ST_SEND;
                    line_j_q <= bit_out ? line_j_q : ~line_j_q;
                    drv_q    <= line_pair(bit_out ? line_j_q : ~line_j_q);
                end
                ST_SEND: begin
                    if (tick) begin
                        if (is_end) begin
                            state_q <= ST_EOP;
                            half_q  <= 1'b0;
                            drv_q   <= PAIR_OFF;
                        end else begin
                            line_j_q <= bit_out ? line_j_q : ~line_j_q;
                            drv_q    <= line_pair(bit_out ? line_j_q : ~line_j_q);
                        end
                    end
                end
                ST_EOP: begin
                    if (tick) begin
                        if (!half_q) begin
                            half_q <= 1'b1;
                        end else begin
                            state_q <= ST_JEND;
                            drv_q   <= line_pair(1'b1);
                        end
                    end
                end
                ST_JEND: begin
                    if (tick) begin
                        state_q    <= ST_IDLE;
                        drv_q      <= PAIR_OFF;
                        oe         <= 1'b0;
                        busy       <= 1'b0;
                        rx_evt_clr <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign dp = drv_q.dp;
    assign dm = drv_q.dm;

    p_idle_released_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!oe && !dp && !dm));

    p_oe_after_j_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> (dm && !dp && $past(dm) && !$past(dp)));

    p_cnt_legal_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !hs_sel) |-> (byte_cnt >= CNT_W'(2) && byte_cnt <= CNT_W'(MAX_BYTES)));

    p_no_se1_r7: assert property (@(posedge clk) disable iff (rst)
        !(dp && dm));

    p_clr_on_release_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rx_evt_clr);

    p_clr_single_r8: assert property (@(posedge clk) disable iff (rst)
        rx_evt_clr |=> !rx_evt_clr);

    p_hs_keeps_addr_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && hs_q) |=> $stable(dev_addr));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (start && busy && state_q != ST_JEND) |=> busy);

endmodule

// File: tb/usb_ls_tx_test.sv
module usb_ls_tx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       hs_sel = 1'b0;
    logic [7:0] hs_pid = 8'h00;
    logic [3:0] byte_cnt = 4'd2;
    logic [3:0] rd_addr;
    logic [7:0] rd_data;
    logic       new_addr_valid = 1'b0;
    logic [6:0] new_addr = 7'd0;
    logic       dp, dm, oe, busy, rx_evt_clr;
    logic [6:0] dev_addr;

    logic [7:0] mem [0:15];
    logic [7:0] pkt [0:11];
    logic       exp_line [0:255];
    int         exp_n;
    int         n_chk = 0;
    int         n_bad = 0;
    logic [6:0] exp_addr = 7'd0;

    localparam int BITC = 11;

    always #2.5 clk = ~clk;

    assign rd_data = mem[rd_addr];

    usb_ls_tx uut (
        .clk(clk), .rst(rst), .start(start), .hs_sel(hs_sel), .hs_pid(hs_pid),
        .byte_cnt(byte_cnt), .rd_addr(rd_addr), .rd_data(rd_data),
        .new_addr_valid(new_addr_valid), .new_addr(new_addr),
        .dp(dp), .dm(dm), .oe(oe), .busy(busy), .dev_addr(dev_addr),
        .rx_evt_clr(rx_evt_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // expected NRZI line levels (1 = J, 0 = K), stuffing per R5
    task automatic build_expect(input int nbytes);
        int  ones = 0;
        logic lvl = 1'b1;
        exp_n = 0;
        for (int b = 0; b < nbytes; b++) begin
            for (int i = 0; i < 8; i++) begin
                logic d = pkt[b][i];
                if (!d) lvl = ~lvl;
                exp_line[exp_n] = lvl;
                exp_n++;
                ones = d ? ones + 1 : 0;
                if (ones == 6) begin
                    lvl = ~lvl;
                    exp_line[exp_n] = lvl;
                    exp_n++;
                    ones = 0;
                end
            end
        end
    endtask

    task automatic run_pkt(input bit hs, input logic [7:0] pid, input int cnt,
                           input bit av, input logic [6:0] na, input bit poke);
        int nb;
        pkt[0] = 8'h80;
        if (hs) begin
            pkt[1] = pid;
            nb = 2;
        end else begin
            for (int i = 1; i < cnt; i++) pkt[i] = mem[i-1];
            nb = cnt;
        end
        build_expect(nb);
        if (!hs && av) exp_addr = na;

        hs_sel = hs; hs_pid = pid; byte_cnt = 4'(cnt);
        new_addr_valid = av; new_addr = na;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(dm && !dp && !oe, "R2 preset J before oe", {oe, dp, dm}, 3'b001);
        chk(busy, "R8 busy after start", busy, 1);
        @(negedge clk);
        chk(oe && dm && !dp, "R2 oe with J", {oe, dp, dm}, 3'b101);
        @(negedge clk);
        for (int k = 0; k < exp_n; k++) begin
            repeat (5) @(negedge clk);
            chk({dp, dm} == {~exp_line[k], exp_line[k]} && oe,
                hs ? "R6 handshake bit" : (k < 8 ? "R3 sync bit" : "R4 R5 data bit"),
                {oe, dp, dm}, {1'b1, ~exp_line[k], exp_line[k]});
            if (poke && k == 3) begin
                start = 1'b1; hs_sel = ~hs;
                @(negedge clk);
                start = 1'b0;
                repeat (5) @(negedge clk);
            end else begin
                repeat (6) @(negedge clk);
            end
        end
        repeat (5) @(negedge clk);
        chk(!dp && !dm && oe, "R7 SE0 first bit", {oe, dp, dm}, 3'b100);
        repeat (11) @(negedge clk);
        chk(!dp && !dm && oe, "R7 SE0 second bit", {oe, dp, dm}, 3'b100);
        chk(dev_addr == exp_addr, "R9 address after EOP start", dev_addr, exp_addr);
        repeat (11) @(negedge clk);
        chk(dm && !dp && oe, "R7 J after SE0", {oe, dp, dm}, 3'b101);
        repeat (5) @(negedge clk);
        chk(busy && !rx_evt_clr, "R8 busy until release", {busy, rx_evt_clr}, 2'b10);
        @(negedge clk);
        chk(!oe && !dp && !dm, "R7 bus released", {oe, dp, dm}, 0);
        chk(!busy && rx_evt_clr, "R8 release clears rx event", {busy, rx_evt_clr}, 2'b01);
        @(negedge clk);
        chk(!rx_evt_clr, "R8 clear is one cycle", rx_evt_clr, 0);
        chk(dev_addr == exp_addr, "R9 address held", dev_addr, exp_addr);
        new_addr_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!oe && !dp && !dm && !busy && !rx_evt_clr, "R1 reset outputs",
            {oe, dp, dm, busy}, 0);
        chk(dev_addr == 7'd0, "R1 reset address", dev_addr, 0);

        // R5: stuffing at end of packet
        mem[0] = 8'hFC;
        run_pkt(1'b0, 8'h00, 2, 1'b0, 7'd0, 1'b0);
        // R5: across byte boundary, R9 commit on data packet
        mem[0] = 8'hFC; mem[1] = 8'h00;
        run_pkt(1'b0, 8'h00, 3, 1'b1, 7'h15, 1'b0);
        // R5 R4: full-length all ones
        for (int i = 0; i < 11; i++) mem[i] = 8'hFF;
        run_pkt(1'b0, 8'h00, 12, 1'b0, 7'd0, 1'b0);
        // R6 R9: ACK handshake ignores byte_cnt, no address commit
        run_pkt(1'b1, 8'hD2, 7, 1'b1, 7'h2A, 1'b0);
        // R6: NAK handshake
        run_pkt(1'b1, 8'h5A, 12, 1'b0, 7'd0, 1'b0);
        // R10: start while busy ignored
        mem[0] = 8'hA5; mem[1] = 8'h3C;
        run_pkt(1'b0, 8'h00, 3, 1'b0, 7'd0, 1'b1);

        // constrained random, fixed seed
        void'($urandom(32'd1234));
        for (int t = 0; t < 24; t++) begin
            bit  hs = ($urandom % 5) == 0;
            int  c  = 2 + ($urandom % 11);
            bit  av = $urandom % 2;
            for (int i = 0; i < 11; i++) mem[i] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
            run_pkt(hs, ($urandom % 2) ? 8'hD2 : 8'h5A, c, av, 7'($urandom), 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule